// File: doc/BRIEF.md
# Table Base Register Parameter Decoder

This block turns the raw contents of a translation unit's table base registers into ready-to-use table parameters. When the unit is switched on, a one-cycle trigger makes it scan the eight 64-bit table base registers. It finds the register that describes the device table and the one that describes the collection table. For each of the two tables it derives a valid flag, the page size in bytes, a two-level flag, the entry size in bytes, the physical base address and the maximum number of entries. In the same cycle it decodes the command-queue base register into a valid flag, a base address and an entry count, and converts the identifier-width fields of the unit's type register into maximum device-ID and collection-ID counts.

All derived values are captured in registers on the trigger and held until the next trigger, so the table-walk and command logic that follows sees stable parameters. The register wrapper around this block delivers the command-queue register with its reserved bits already removed. It also passes the identifier-width fields of the type register as separate inputs.

Table base register layout (all bits used):
- bit 63: valid
- bit 62: two-level (indirect)
- [61:56]: table kind
- [55:48]: entry bytes minus one
- [47:12]: address
- [11:10]: page code
- [9:0]: pages minus one

Top module: `tbl_param_decoder`

## Requirements
- R1: The page code in bits [11:10] of a table register selects the page size: 0 gives 4096 bytes, 1 gives 16384 bytes, and both 2 and 3 give 65536 bytes.
- R2: On a trigger, table registers that are all zero are skipped. Kind 1 in bits [61:56] describes the device table and kind 4 describes the collection table; every other kind is ignored. When several registers name the same table, the one with the highest index wins. A table named by no register keeps its previous outputs. Bit 62 gives the two-level flag.
- R3: When the selected register of a table has bit 63 clear, every derived output of that table is zero.
- R4: With 4 KB or 16 KB pages, the base address equals register bits [47:12] in the same positions, with all other bits zero.
- R5: With 64 KB pages, base address bits [47:16] come from the same register bits. Register bits [15:12] become address bits [51:48], and address bits [15:0] are zero.
- R6: For a flat table (bit 62 clear), the maximum entry count is (pages × page size) / entry bytes. Pages is bits [9:0] plus one.
- R7: For a two-level table, the maximum entry count is ((pages × page size) / 8) × (page size / entry bytes).
- R8: The entry size in bytes is bits [55:48] plus one and must be a power of two.
- R9: The maximum device-ID count is 2^(dev_id_bits_i+1).
- R10: The maximum collection-ID count is 2^(coll_id_bits_i+1) when coll_id_limit_i is set, and 65536 otherwise.
- R11: In the command-queue register, bit 52 is valid, bits [51:12] are the address and bits [11:0] are pages minus one. When the queue is valid, its base is those address bits in place and its entry count is pages × 4096 / 32. When it is not valid, both are zero.
- R12: done_o is high exactly in the cycle after a trigger cycle, and all outputs change only on the clock edge that samples the trigger.
- R13: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | Decode trigger (unit enable) |
| base_regs_i | input | 512 | Eight table base registers, register n at bits [64n+63:64n] |
| cq_reg_i | input | 53 | Command-queue base register, reserved bits removed |
| dev_id_bits_i | input | 5 | Device-ID width minus one |
| coll_id_bits_i | input | 4 | Collection-ID width minus one |
| coll_id_limit_i | input | 1 | Collection-ID width field is in force |
| dev_valid_o | output | 1 | Device table valid |
| dev_page_bytes_o | output | 17 | Device table page size in bytes |
| dev_indirect_o | output | 1 | Device table is two-level |
| dev_entry_bytes_o | output | 9 | Device table entry size in bytes |
| dev_base_o | output | 52 | Device table base address |
| dev_max_entries_o | output | 40 | Device table maximum entries |
| col_valid_o | output | 1 | Collection table valid |
| col_page_bytes_o | output | 17 | Collection table page size in bytes |
| col_indirect_o | output | 1 | Collection table is two-level |
| col_entry_bytes_o | output | 9 | Collection table entry size in bytes |
| col_base_o | output | 52 | Collection table base address |
| col_max_entries_o | output | 40 | Collection table maximum entries |
| cq_valid_o | output | 1 | Command queue valid |
| cq_base_o | output | 52 | Command queue base address |
| cq_max_entries_o | output | 20 | Command queue entry count |
| max_dev_ids_o | output | 33 | Maximum device-ID count |
| max_coll_ids_o | output | 17 | Maximum collection-ID count |
| done_o | output | 1 | Outputs updated (one cycle after trigger) |

## Verification
The decoder is driven with these fixed patterns:
- one with 4 KB and 16 KB flat tables, which separates the two narrow page codes and the flat sizing rule;
- one with 64 KB two-level tables using both page codes 2 and 3, with nonzero high address bits, which exposes the split address and the two-level formula;
- one with an invalid device register next to an ignored kind and no collection register, which separates clearing from holding;
- one where two registers name the device table, which shows which index has priority;
- one with all-zero registers, and one with maximum field values at the widest counts.

Random register sets with power-of-two entry sizes follow. After every trigger the inputs are disturbed with the trigger low, to show that the outputs hold.

// File: rtl/tbd_pkg.sv
// Shared widths, field positions and parameter records for the table base
// register decoder. Assumes 64-bit table registers and a 53-bit command-queue
// register whose reserved bits have been removed by the register wrapper.
package tbd_pkg;
    localparam int REG_W        = 64;
    localparam int ADDR_W       = 52;
    localparam int ENT_W        = 40;
    localparam int PGB_W        = 17;
    localparam int ESZ_FLD_W    = 8;
    localparam int EB_W         = ESZ_FLD_W + 1;
    localparam int ESL_W        = 4;
    localparam int TYPE_W       = 6;
    localparam int SIZE_W       = 10;
    localparam int PGC_W        = 2;
    localparam int CQ_REG_W     = 53;
    localparam int CQ_SIZE_W    = 12;
    localparam int CQMAX_W      = 20;
    localparam int DEVB_W       = 5;
    localparam int CIDB_W       = 4;
    localparam int DEVID_W      = 33;
    localparam int COLLID_W     = 17;
    localparam int L1_LOG2      = 3;
    localparam int CMD_LOG2     = 5;
    localparam int CQ_PAGE_LOG2 = 12;
    localparam int NUM_TBL      = 2;

    // table register field positions
    localparam int VALID_BIT = 63;
    localparam int INDIR_BIT = 62;
    localparam int TYPE_LSB  = 56;
    localparam int ESZ_LSB   = 48;
    localparam int ADDR_HI   = 47;
    localparam int ADDR_LO   = 12;
    localparam int A64_LO    = 16;
    localparam int HI64_LSB  = 12;
    localparam int PGC_LSB   = 10;
    localparam int SIZE_LSB  = 0;

    // command-queue register field positions
    localparam int CQ_VALID_BIT = 52;
    localparam int CQ_ADDR_HI   = 51;
    localparam int CQ_ADDR_LO   = 12;

    localparam logic [TYPE_W-1:0] KIND_DEV = 6'd1;
    localparam logic [TYPE_W-1:0] KIND_COL = 6'd4;

    typedef struct packed {
        logic              valid;
        logic [PGB_W-1:0]  page_bytes;
        logic              indirect;
        logic [EB_W-1:0]   entry_bytes;
        logic [ADDR_W-1:0] base;
        logic [ENT_W-1:0]  max_entries;
    } tbl_params_t;

    typedef struct packed {
        logic               valid;
        logic [ADDR_W-1:0]  base;
        logic [CQMAX_W-1:0] max_entries;
    } cq_params_t;
endpackage

// File: rtl/tbd_base_select.sv
// Scans the table base registers for the one describing table kind KIND.
// All-zero registers are skipped; the highest matching index wins.
module tbd_base_select
    import tbd_pkg::*;
#(
    parameter int                NUM_BASE = 8,
    parameter logic [TYPE_W-1:0] KIND     = KIND_DEV
) (
    input  logic [NUM_BASE*REG_W-1:0] regs_i,
    output logic                      hit_o,
    output logic [REG_W-1:0]          reg_o
);
    logic [REG_W-1:0] cand;

    // priority scan, later indices overwrite earlier matches
    always_comb begin
        hit_o = 1'b0;
        reg_o = '0;
        cand  = '0;
        for (int i = 0; i < NUM_BASE; i++) begin
            cand = regs_i[i*REG_W +: REG_W];
            if ((cand != '0) && (cand[TYPE_LSB +: TYPE_W] == KIND)) begin
                hit_o = 1'b1;
                reg_o = cand;
            end
        end
    end
endmodule

// File: rtl/tbd_tbl_decode.sv
// Derives table parameters from one table base register. Assumes the entry
// size is a power of two so every division reduces to a right shift.
module tbd_tbl_decode
    import tbd_pkg::*;
(
    input  logic [REG_W-1:0] reg_i,
    output tbl_params_t      params_o
);
    logic [4:0]        pg_log;
    logic [EB_W-1:0]   eb;
    logic [ESL_W-1:0]  es_log;
    logic [ENT_W-1:0]  span;
    logic [4:0]        sh;
    logic [ADDR_W-1:0] base;

    // page size, entry size and its log2
    always_comb begin
        case (reg_i[PGC_LSB +: PGC_W])
            2'd0:    pg_log = 5'd12;
            2'd1:    pg_log = 5'd14;
            default: pg_log = 5'd16;
        endcase
        eb = {1'b0, reg_i[ESZ_LSB +: ESZ_FLD_W]} + EB_W'(1);
        es_log = '0;
        for (int b = 0; b < EB_W; b++) begin
            if (eb[b]) es_log = ESL_W'(b);
        end
        span = (ENT_W'(reg_i[SIZE_LSB +: SIZE_W]) + ENT_W'(1)) << pg_log;
        sh   = pg_log - {1'b0, es_log};
    end

    // base address, split form for the largest page size
    always_comb begin
        base = '0;
        base[ADDR_HI:ADDR_LO] = reg_i[ADDR_HI:ADDR_LO];
        if (pg_log == 5'd16) begin
            base[A64_LO-1:ADDR_LO] = '0;
            base[ADDR_W-1:ADDR_W-4] = reg_i[HI64_LSB +: 4];
        end
    end

    // gather outputs, all zero for an invalid register
    always_comb begin
        params_o = '0;
        if (reg_i[VALID_BIT]) begin
            params_o.valid       = 1'b1;
            params_o.page_bytes  = PGB_W'(1) << pg_log;
            params_o.indirect    = reg_i[INDIR_BIT];
            params_o.entry_bytes = eb;
            params_o.base        = base;
            params_o.max_entries = reg_i[INDIR_BIT] ? ((span >> L1_LOG2) << sh)
                                                    : (span >> es_log);
        end
    end
endmodule

// File: rtl/tbd_cq_decode.sv
// Derives command-queue base and entry count. Assumes fixed 4 KB pages and
// fixed-size commands, so the count is a pure shift of the page count.
module tbd_cq_decode
    import tbd_pkg::*;
(
    input  logic [CQ_REG_W-1:0] reg_i,
    output cq_params_t          params_o
);
    // decode queue fields, zero when invalid
    always_comb begin
        params_o = '0;
        if (reg_i[CQ_VALID_BIT]) begin
            params_o.valid = 1'b1;
            params_o.base[CQ_ADDR_HI:CQ_ADDR_LO] = reg_i[CQ_ADDR_HI:CQ_ADDR_LO];
            params_o.max_entries = (CQMAX_W'(reg_i[CQ_SIZE_W-1:0]) + CQMAX_W'(1))
                                   << (CQ_PAGE_LOG2 - CMD_LOG2);
        end
    end
endmodule

// File: rtl/tbd_id_limits.sv
// Converts identifier-width fields into identifier counts. Assumes the
// collection count defaults to 16 bits when the width field is not in force.
module tbd_id_limits
    import tbd_pkg::*;
(
    input  logic [DEVB_W-1:0]   dev_bits_i,
    input  logic [CIDB_W-1:0]   coll_bits_i,
    input  logic                coll_limit_i,
    output logic [DEVID_W-1:0]  dev_ids_o,
    output logic [COLLID_W-1:0] coll_ids_o
);
    // power-of-two counts from width-minus-one fields
    always_comb begin
        dev_ids_o  = DEVID_W'(1) << ({1'b0, dev_bits_i} + 6'd1);
        coll_ids_o = coll_limit_i ? (COLLID_W'(1) << ({1'b0, coll_bits_i} + 5'd1))
                                  : (COLLID_W'(1) << 16);
    end
endmodule

// File: rtl/tbl_param_decoder.sv
// Top: decodes device table, collection table, command queue and ID limits
// on a trigger and holds them in registers. Assumes the trigger is a pulse
// raised when the unit is enabled; inputs are stable in that cycle.
module tbl_param_decoder
    import tbd_pkg::*;
#(
    parameter int NUM_BASE = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      trig_i,
    input  logic [NUM_BASE*REG_W-1:0] base_regs_i,
    input  logic [CQ_REG_W-1:0]       cq_reg_i,
    input  logic [DEVB_W-1:0]         dev_id_bits_i,
    input  logic [CIDB_W-1:0]         coll_id_bits_i,
    input  logic                      coll_id_limit_i,
    output logic                      dev_valid_o,
    output logic [PGB_W-1:0]          dev_page_bytes_o,
    output logic                      dev_indirect_o,
    output logic [EB_W-1:0]           dev_entry_bytes_o,
    output logic [ADDR_W-1:0]         dev_base_o,
    output logic [ENT_W-1:0]          dev_max_entries_o,
    output logic                      col_valid_o,
    output logic [PGB_W-1:0]          col_page_bytes_o,
    output logic                      col_indirect_o,
    output logic [EB_W-1:0]           col_entry_bytes_o,
    output logic [ADDR_W-1:0]         col_base_o,
    output logic [ENT_W-1:0]          col_max_entries_o,
    output logic                      cq_valid_o,
    output logic [ADDR_W-1:0]         cq_base_o,
    output logic [CQMAX_W-1:0]        cq_max_entries_o,
    output logic [DEVID_W-1:0]        max_dev_ids_o,
    output logic [COLLID_W-1:0]       max_coll_ids_o,
    output logic                      done_o
);
    logic [NUM_TBL-1:0] hit;
    logic [REG_W-1:0]   sel     [NUM_TBL];
    tbl_params_t        tbl_d   [NUM_TBL];
    tbl_params_t        tbl_q   [NUM_TBL];
    cq_params_t         cq_d, cq_q;
    logic [DEVID_W-1:0]  dev_ids_d, dev_ids_q;
    logic [COLLID_W-1:0] coll_ids_d, coll_ids_q;
    logic                done_q;

    for (genvar k = 0; k < NUM_TBL; k++) begin : g_tbl
        localparam logic [TYPE_W-1:0] KIND = (k == 0) ? KIND_DEV : KIND_COL;
        tbd_base_select #(.NUM_BASE(NUM_BASE), .KIND(KIND)) u_sel (
            .regs_i (base_regs_i),
            .hit_o  (hit[k]),
            .reg_o  (sel[k])
        );
        tbd_tbl_decode u_dec (
            .reg_i    (sel[k]),
            .params_o (tbl_d[k])
        );
    end

    tbd_cq_decode u_cq (
        .reg_i    (cq_reg_i),
        .params_o (cq_d)
    );

    tbd_id_limits u_ids (
        .dev_bits_i   (dev_id_bits_i),
        .coll_bits_i  (coll_id_bits_i),
        .coll_limit_i (coll_id_limit_i),
        .dev_ids_o    (dev_ids_d),
        .coll_ids_o   (coll_ids_d)
    );

    // capture decoded parameters on trigger; unnamed tables hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NUM_TBL; k++) tbl_q[k] <= '0;
            cq_q       <= '0;
            dev_ids_q  <= '0;
            coll_ids_q <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= trig_i;
            if (trig_i) begin
                for (int k = 0; k < NUM_TBL; k++) begin
                    if (hit[k]) tbl_q[k] <= tbl_d[k];
                end
                cq_q       <= cq_d;
                dev_ids_q  <= dev_ids_d;
                coll_ids_q <= coll_ids_d;
            end
        end
    end

    assign dev_valid_o       = tbl_q[0].valid;
    assign dev_page_bytes_o  = tbl_q[0].page_bytes;
    assign dev_indirect_o    = tbl_q[0].indirect;
    assign dev_entry_bytes_o = tbl_q[0].entry_bytes;
    assign dev_base_o        = tbl_q[0].base;
    assign dev_max_entries_o = tbl_q[0].max_entries;
    assign col_valid_o       = tbl_q[1].valid;
    assign col_page_bytes_o  = tbl_q[1].page_bytes;
    assign col_indirect_o    = tbl_q[1].indirect;
    assign col_entry_bytes_o = tbl_q[1].entry_bytes;
    assign col_base_o        = tbl_q[1].base;
    assign col_max_entries_o = tbl_q[1].max_entries;
    assign cq_valid_o        = cq_q.valid;
    assign cq_base_o         = cq_q.base;
    assign cq_max_entries_o  = cq_q.max_entries;
    assign max_dev_ids_o     = dev_ids_q;
    assign max_coll_ids_o    = coll_ids_q;
    assign done_o            = done_q;
endmodule

// File: rtl/tbd_checker.sv
// Assertion checker for tbl_param_decoder, attached by bind below.
module tbd_checker
    import tbd_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                trig_i,
    input logic                coll_id_limit_i,
    input logic                dev_valid_o,
    input logic [PGB_W-1:0]    dev_page_bytes_o,
    input logic                dev_indirect_o,
    input logic [EB_W-1:0]     dev_entry_bytes_o,
    input logic [ADDR_W-1:0]   dev_base_o,
    input logic [ENT_W-1:0]    dev_max_entries_o,
    input logic                col_valid_o,
    input logic [PGB_W-1:0]    col_page_bytes_o,
    input logic                col_indirect_o,
    input logic [EB_W-1:0]     col_entry_bytes_o,
    input logic [ADDR_W-1:0]   col_base_o,
    input logic [ENT_W-1:0]    col_max_entries_o,
    input logic                cq_valid_o,
    input logic [ADDR_W-1:0]   cq_base_o,
    input logic [CQMAX_W-1:0]  cq_max_entries_o,
    input logic [DEVID_W-1:0]  max_dev_ids_o,
    input logic [COLLID_W-1:0] max_coll_ids_o,
    input logic                done_o
);
    p_done_after_trig_r12: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> done_o);

    p_no_stray_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_i |=> !done_o);

    p_hold_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_i |=> $stable({dev_valid_o, dev_page_bytes_o, dev_indirect_o,
                             dev_entry_bytes_o, dev_base_o, dev_max_entries_o,
                             col_valid_o, col_page_bytes_o, col_indirect_o,
                             col_entry_bytes_o, col_base_o, col_max_entries_o,
                             cq_valid_o, cq_base_o, cq_max_entries_o,
                             max_dev_ids_o, max_coll_ids_o}));

    p_dev_invalid_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_valid_o |-> (dev_page_bytes_o == '0 && !dev_indirect_o &&
                          dev_entry_bytes_o == '0 && dev_base_o == '0 &&
                          dev_max_entries_o == '0));

    p_col_invalid_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid_o |-> (col_page_bytes_o == '0 && !col_indirect_o &&
                          col_entry_bytes_o == '0 && col_base_o == '0 &&
                          col_max_entries_o == '0));

    p_page_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dev_valid_o |-> (dev_page_bytes_o == 17'd4096 || dev_page_bytes_o == 17'd16384 ||
                         dev_page_bytes_o == 17'd65536));

    p_coll_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && !coll_id_limit_i) |=> (max_coll_ids_o == 17'h10000));

    p_cq_invalid_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cq_valid_o |-> (cq_base_o == '0 && cq_max_entries_o == '0));

    p_dev_ids_pow2_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($countones(max_dev_ids_o) == 1));
endmodule

bind tbl_param_decoder tbd_checker i_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .trig_i            (trig_i),
    .coll_id_limit_i   (coll_id_limit_i),
    .dev_valid_o       (dev_valid_o),
    .dev_page_bytes_o  (dev_page_bytes_o),
    .dev_indirect_o    (dev_indirect_o),
    .dev_entry_bytes_o (dev_entry_bytes_o),
    .dev_base_o        (dev_base_o),
    .dev_max_entries_o (dev_max_entries_o),
    .col_valid_o       (col_valid_o),
    .col_page_bytes_o  (col_page_bytes_o),
    .col_indirect_o    (col_indirect_o),
    .col_entry_bytes_o (col_entry_bytes_o),
    .col_base_o        (col_base_o),
    .col_max_entries_o (col_max_entries_o),
    .cq_valid_o        (cq_valid_o),
    .cq_base_o         (cq_base_o),
    .cq_max_entries_o  (cq_max_entries_o),
    .max_dev_ids_o     (max_dev_ids_o),
    .max_coll_ids_o    (max_coll_ids_o),
    .done_o            (done_o)
);

// File: tb/test_tbl_param_decoder.sv
`timescale 1ns/1ps
module test_tbl_param_decoder;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         trig_i = 1'b0;
    logic [511:0] base_regs_i = '0;
    logic [52:0]  cq_reg_i = '0;
    logic [4:0]   dev_id_bits_i = '0;
    logic [3:0]   coll_id_bits_i = '0;
    logic         coll_id_limit_i = 1'b0;
    logic         dev_valid_o, dev_indirect_o, col_valid_o, col_indirect_o, cq_valid_o, done_o;
    logic [16:0]  dev_page_bytes_o, col_page_bytes_o, max_coll_ids_o;
    logic [8:0]   dev_entry_bytes_o, col_entry_bytes_o;
    logic [51:0]  dev_base_o, col_base_o, cq_base_o;
    logic [39:0]  dev_max_entries_o, col_max_entries_o;
    logic [19:0]  cq_max_entries_o;
    logic [32:0]  max_dev_ids_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    typedef struct {
        logic [63:0] v, pb, ind, eb, base, mx;
    } tbl_m_t;
    typedef struct {
        tbl_m_t      dev, col;
        logic [63:0] qv, qbase, qmx, devids, collids;
    } exp_t;

    exp_t cur;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    tbl_param_decoder i_tbl_param_decoder (.*);

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(bit v, bit ind, int kind, int esf,
                                       logic [63:0] addr, int pg, int sz);
        logic [63:0] r = '0;
        r[63] = v; r[62] = ind; r[61:56] = 6'(kind); r[55:48] = 8'(esf);
        r[47:12] = addr[47:12]; r[11:10] = 2'(pg); r[9:0] = 10'(sz);
        return r;
    endfunction

    function automatic tbl_m_t dec_tbl(logic [63:0] r);
        tbl_m_t t = '{default: 64'd0};
        logic [63:0] n;
        if (!r[63]) return t;
        t.v   = 1;
        t.pb  = (r[11:10] == 0) ? 4096 : (r[11:10] == 1) ? 16384 : 65536;
        t.ind = {63'd0, r[62]};
        t.eb  = 64'(r[55:48]) + 1;
        n     = 64'(r[9:0]) + 1;
        t.mx  = r[62] ? (n * t.pb / 8) * (t.pb / t.eb) : (n * t.pb / t.eb);
        t.base = (t.pb < 65536) ? (r & 64'h0000_FFFF_FFFF_F000)
                                : ((r & 64'h0000_FFFF_FFFF_0000) | (64'(r[15:12]) << 48));
        return t;
    endfunction

    task automatic cmp_tbl(string nm, tbl_m_t e, logic v, logic [16:0] pb, logic ind,
                           logic [8:0] eb, logic [51:0] base, logic [39:0] mx, string ov);
        string rv = (ov != "") ? ov : (e.v == 0) ? "R3" : "R2";
        chk(rv, {nm, " valid"}, 64'(v), e.v);
        chk((ov != "") ? ov : (e.v == 0) ? "R3" : "R1", {nm, " page bytes"}, 64'(pb), e.pb);
        chk(rv, {nm, " indirect"}, 64'(ind), e.ind);
        chk((ov != "") ? ov : (e.v == 0) ? "R3" : "R8", {nm, " entry bytes"}, 64'(eb), e.eb);
        chk((ov != "") ? ov : (e.v == 0) ? "R3" : (e.pb == 65536) ? "R5" : "R4",
            {nm, " base"}, 64'(base), e.base);
        chk((ov != "") ? ov : (e.v == 0) ? "R3" : (e.ind != 0) ? "R7" : "R6",
            {nm, " max entries"}, 64'(mx), e.mx);
    endtask

    task automatic cmp_all(exp_t e, string ov);
        cmp_tbl("dev", e.dev, dev_valid_o, dev_page_bytes_o, dev_indirect_o,
                dev_entry_bytes_o, dev_base_o, dev_max_entries_o, ov);
        cmp_tbl("col", e.col, col_valid_o, col_page_bytes_o, col_indirect_o,
                col_entry_bytes_o, col_base_o, col_max_entries_o, ov);
        chk((ov != "") ? ov : "R11", "cq valid", 64'(cq_valid_o), e.qv);
        chk((ov != "") ? ov : "R11", "cq base", 64'(cq_base_o), e.qbase);
        chk((ov != "") ? ov : "R11", "cq entries", 64'(cq_max_entries_o), e.qmx);
        chk((ov != "") ? ov : "R9", "dev ids", 64'(max_dev_ids_o), e.devids);
        chk((ov != "") ? ov : "R10", "coll ids", 64'(max_coll_ids_o), e.collids);
    endtask

    // monitor: pop expected item whenever the design reports done
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb_q.size() == 0) chk("R12", "done without pending trigger", 1, 0);
            else cmp_all(sb_q.pop_front(), "");
        end
    end

    // driver: apply a register set, predict, pulse trigger, disturb inputs
    task automatic fire(logic [511:0] regs, logic [52:0] cq, int db, int cb, bit cl);
        @(negedge clk);
        base_regs_i = regs; cq_reg_i = cq;
        dev_id_bits_i = 5'(db); coll_id_bits_i = 4'(cb); coll_id_limit_i = cl;
        for (int i = 0; i < 8; i++) begin
            logic [63:0] r = regs[i*64 +: 64];
            if (r == 0) continue;
            if (r[61:56] == 6'd1) cur.dev = dec_tbl(r);
            else if (r[61:56] == 6'd4) cur.col = dec_tbl(r);
        end
        cur.qv    = {63'd0, cq[52]};
        cur.qbase = cq[52] ? (64'(cq[51:12]) << 12) : 0;
        cur.qmx   = cq[52] ? ((64'(cq[11:0]) + 1) * 4096 / 32) : 0;
        cur.devids  = 64'd1 << (db + 1);
        cur.collids = cl ? (64'd1 << (cb + 1)) : 64'd65536;
        sb_q.push_back(cur);
        trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
        chk("R12", "done one cycle after trigger", 64'(done_o), 1);
        base_regs_i = {16{$urandom}};
        cq_reg_i = 53'({$urandom, $urandom});
        dev_id_bits_i = 5'($urandom); coll_id_bits_i = 4'($urandom);
        coll_id_limit_i = ~coll_id_limit_i;
        @(negedge clk);
        chk("R12", "done drops after one cycle", 64'(done_o), 0);
        @(negedge clk);
        cmp_all(cur, "R12");
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [511:0] regs;
        exp_t zero;
        zero.dev = '{default: 64'd0}; zero.col = '{default: 64'd0};
        zero.qv = 0; zero.qbase = 0; zero.qmx = 0; zero.devids = 0; zero.collids = 0;
        cur = zero;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_all(zero, "R13");
        chk("R13", "done after reset", 64'(done_o), 0);

        // R1 R4 R6: 4K and 16K flat tables, fixed collection width
        regs = '0;
        regs[0*64 +: 64] = mk(1, 0, 1, 7, 64'h0000_1234_5678_9000, 0, 3);
        regs[3*64 +: 64] = mk(1, 0, 4, 15, 64'h0000_0ABC_DEF0_3000, 1, 9);
        fire(regs, {1'b1, 40'h12_3456_7890, 12'd5}, 15, 3, 0);

        // R5 R7 R10: 64K two-level tables, page codes 2 and 3, high address bits
        regs = '0;
        regs[2*64 +: 64] = mk(1, 1, 1, 3, 64'h0000_7654_3210_A000, 2, 1);
        regs[5*64 +: 64] = mk(1, 1, 4, 63, 64'h0000_1111_2222_5000, 3, 20);
        fire(regs, {1'b1, 40'hFF_0000_0001, 12'd0}, 7, 7, 1);

        // R2 R3: invalid device register, ignored kind, collection held
        regs = '0;
        regs[1*64 +: 64] = mk(0, 1, 1, 7, 64'h0000_5555_0000_1000, 1, 4);
        regs[4*64 +: 64] = mk(1, 0, 2, 7, 64'h0000_9999_0000_1000, 0, 4);
        fire(regs, {1'b1, 40'h00_0000_1000, 12'd1}, 3, 2, 1);

        // R2: highest index wins for the device table
        regs = '0;
        regs[1*64 +: 64] = mk(1, 0, 1, 0, 64'h0000_0000_0001_0000, 0, 0);
        regs[6*64 +: 64] = mk(1, 0, 1, 31, 64'h0000_0000_0BAD_0000, 1, 7);
        regs[4*64 +: 64] = mk(1, 1, 4, 255, 64'h0000_0000_0C0C_0000, 0, 2);
        fire(regs, {1'b1, 40'h00_0000_2000, 12'd2}, 9, 0, 1);

        // R11: invalid queue with other bits set
        fire(regs, {1'b0, 40'hFF_FFFF_FFFF, 12'hFFF}, 0, 0, 0);

        // R2: all-zero registers leave both tables unchanged
        fire('0, {1'b1, 40'h00_0000_0003, 12'd7}, 1, 1, 0);

        // R7 R9 R10 R11: widest counts
        regs = '0;
        regs[7*64 +: 64] = mk(1, 1, 1, 0, 64'h0000_FFFF_FFFF_F000, 3, 1023);
        regs[0*64 +: 64] = mk(1, 0, 4, 0, 64'h0000_FFFF_FFFF_F000, 2, 1023);
        fire(regs, {1'b1, 40'hFF_FFFF_FFFF, 12'hFFF}, 31, 15, 1);

        // random register sets with power-of-two entry sizes
        for (int t = 0; t < 30; t++) begin
            regs = '0;
            for (int i = 0; i < 8; i++) begin
                int kinds[4] = '{0, 1, 2, 4};
                if ($urandom_range(0, 3) == 0) continue;
                regs[i*64 +: 64] = mk(1'($urandom), 1'($urandom), kinds[$urandom_range(0, 3)],
                                      (1 << $urandom_range(0, 8)) - 1,
                                      {$urandom, $urandom}, $urandom_range(0, 3),
                                      $urandom_range(0, 1023));
            end
            fire(regs, 53'({$urandom, $urandom}), $urandom_range(0, 31),
                 $urandom_range(0, 15), 1'($urandom));
        end

        repeat (3) @(negedge clk);
        chk("R12", "every trigger produced done", 64'(sb_q.size()), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule